// File: doc/BRIEF.md
# Byte-Serial Reflected CRC-32 Generator and Checker

This block computes a 32-bit cyclic redundancy check over a message presented one byte per accepted cycle. It uses the common CRC-32 generator polynomial in its bit-reflected form, so the least significant bit of every byte enters the calculation first. A start-of-message strobe, given together with the first byte, reloads the register. An end-of-message strobe, given with the last byte, makes the finished value appear on the output one cycle later, with a one-cycle done pulse.

A configuration input selects the output form. One setting gives the register contents unchanged (the variant without a final inversion). The other gives the conventional result, with all 32 bits inverted. For receive paths, a check input makes the block compare the register, after a message and its appended CRC (least significant byte first), against the fixed residue for the selected form, and raise a match flag alongside the done pulse.

Every incoming bit decides whether the polynomial is folded in. None of the trailing message bits is simply XORed into the result.

Top module: `crc32_engine`

## Requirements
- R1: While reset is held and after it is released, crcOut is 0, doneOut is 0 and crcOkOut is 0 until a message ends.
- R2: For each accepted byte, the byte is XORed into register bits 7:0. The register then shifts right eight times, XORing 0xEDB88320 after any shift whose outgoing bit was 1. Each message starts from 0xFFFFFFFF.
- R3: A byte accepted with sopIn high is processed against the value 0xFFFFFFFF in that same cycle. Any partial message before it is discarded.
- R4: While validIn is low, dataIn, sopIn and eopIn have no effect: a message with idle cycles between its bytes gives the same result as one without.
- R5: With cfgInvert = 1, the result is the register XOR 0xFFFFFFFF. The single byte 0x00 gives 0xD202EF8D, the single byte 0x01 gives 0xA505DF1B, and the ASCII string "123456789" gives 0xCBF43926.
- R6: With cfgInvert = 0, the result is the register value unchanged. "123456789" gives 0x340BC6D9.
- R7: doneOut is high for exactly the cycle after a byte is accepted with eopIn high, and crcOut takes the new result at that same edge. crcOut holds its value at all other times.
- R8: With cfgCheck = 1 at the final byte, crcOkOut rises together with doneOut when the register equals the residue: 0xDEBB20E3 for cfgInvert = 1 (the result then reads 0x2144DF1C), and 0x00000000 for cfgInvert = 0.
- R9: crcOkOut stays low when cfgCheck = 0 at the final byte, or when the register differs from the residue.
- R10: Every message bit affects the polynomial decisions. Changing the first byte of a longer message, or only its last byte, changes the result as the R2 rule predicts, not by a plain XOR of the changed bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Byte on dataIn is accepted this cycle |
| sopIn | input | 1 | Accepted byte is the first of a message |
| eopIn | input | 1 | Accepted byte is the last of a message |
| dataIn | input | 8 | Message byte, least significant bit processed first |
| cfgInvert | input | 1 | 1: output inverted (standard form); 0: raw register |
| cfgCheck | input | 1 | 1: compare the final register against the residue |
| crcOut | output | 32 | CRC result of the last completed message |
| doneOut | output | 1 | One-cycle pulse when crcOut is updated |
| crcOkOut | output | 1 | Residue match, valid with doneOut |

## Verification
The bench builds the block with its default parameters: an 8-bit data byte, a 32-bit register, the reflected polynomial 0xEDB88320, an all-ones start value and the standard residue 0xDEBB20E3. With these values, results can be compared with widely published check values for both output forms. The appended-CRC residue can be exercised in both modes. Multi-byte messages show that no trailing bits bypass the feedback.

// File: rtl/crc32_pkg.sv
`timescale 1ns/1ps
package crc32_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // restart from the initial value with this byte
    logic step;    // fold the current byte into the register
    logic finish;  // this byte ends the message
  } crcCtl_t;
endpackage

// File: rtl/crc32_ctrl.sv
`timescale 1ns/1ps
module crc32_ctrl
  import crc32_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    validIn,
  input  logic    sopIn,
  input  logic    eopIn,
  output crcCtl_t ctl,
  output logic    doneOut
);
  always_comb begin
    ctl.step   = validIn;
    ctl.load   = validIn & sopIn;
    ctl.finish = validIn & eopIn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) doneOut <= 1'b0;
    else        doneOut <= ctl.finish;
  end

  // R7: a done pulse only follows an accepted end-of-message byte
  assert_done_after_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |-> $past(validIn && eopIn));
endmodule

// File: rtl/crc32_datapath.sv
`timescale 1ns/1ps
module crc32_datapath
  import crc32_pkg::*;
#(
  parameter int          CRC_W       = 32,
  parameter int          DATA_W      = 8,
  parameter logic [31:0] POLY_REFL   = 32'hEDB88320,
  parameter logic [31:0] INIT_VAL    = 32'hFFFFFFFF,
  parameter logic [31:0] RESIDUE_INV = 32'hDEBB20E3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  crcCtl_t           ctl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cfgInvert,
  input  logic              cfgCheck,
  output logic [CRC_W-1:0]  crcOut,
  output logic              crcOkOut
);
  localparam int PAD_W = CRC_W - DATA_W;
  localparam logic [CRC_W-1:0] ALL_ONES = {CRC_W{1'b1}};

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] baseVal;
  logic [CRC_W-1:0] nextCrc;
  logic [CRC_W-1:0] residue;
  logic [CRC_W-1:0] stage [0:DATA_W];

  // A start-of-message byte bypasses the old register contents
  assign baseVal  = ctl.load ? INIT_VAL[CRC_W-1:0] : crcReg;
  assign stage[0] = baseVal ^ {{PAD_W{1'b0}}, dataIn};

  // One shift-and-fold stage per data bit, LSB first
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bitStage
      assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY_REFL[CRC_W-1:0])
                                      : (stage[i] >> 1);
    end
  endgenerate

  assign nextCrc = stage[DATA_W];
  assign residue = cfgInvert ? RESIDUE_INV[CRC_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crcReg   <= INIT_VAL[CRC_W-1:0];
      crcOut   <= '0;
      crcOkOut <= 1'b0;
    end else begin
      if (ctl.step)   crcReg <= nextCrc;
      if (ctl.finish) crcOut <= cfgInvert ? (nextCrc ^ ALL_ONES) : nextCrc;
      crcOkOut <= ctl.finish && cfgCheck && (nextCrc == residue);
    end
  end

  // R4: without an accepted byte the register keeps its value
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.step |=> $stable(crcReg));
endmodule

// File: rtl/crc32_engine.sv
`timescale 1ns/1ps
module crc32_engine
  import crc32_pkg::*;
#(
  parameter int          CRC_W       = 32,
  parameter int          DATA_W      = 8,
  parameter logic [31:0] POLY_REFL   = 32'hEDB88320,
  parameter logic [31:0] INIT_VAL    = 32'hFFFFFFFF,
  parameter logic [31:0] RESIDUE_INV = 32'hDEBB20E3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              validIn,
  input  logic              sopIn,
  input  logic              eopIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cfgInvert,
  input  logic              cfgCheck,
  output logic [CRC_W-1:0]  crcOut,
  output logic              doneOut,
  output logic              crcOkOut
);
  crcCtl_t ctl;

  crc32_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .validIn(validIn), .sopIn(sopIn),
    .eopIn(eopIn), .ctl(ctl), .doneOut(doneOut)
  );

  crc32_datapath #(
    .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY_REFL(POLY_REFL),
    .INIT_VAL(INIT_VAL), .RESIDUE_INV(RESIDUE_INV)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .dataIn(dataIn),
    .cfgInvert(cfgInvert), .cfgCheck(cfgCheck),
    .crcOut(crcOut), .crcOkOut(crcOkOut)
  );

  // R7: the result only changes together with the done pulse
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !doneOut |-> $stable(crcOut));
  // R8: a match is only reported with the done pulse
  assert_ok_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crcOkOut |-> doneOut);
  // R9: no match without check mode at the final byte
  assert_ok_needs_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
    crcOkOut |-> $past(cfgCheck));
endmodule

// File: tb/tb_crc32_engine.sv
`timescale 1ns/1ps
module tb_crc32_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        validIn = 1'b0, sopIn = 1'b0, eopIn = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        cfgInvert = 1'b0, cfgCheck = 1'b0;
  logic [31:0] crcOut;
  logic        doneOut, crcOkOut;

  int errors = 0;
  int checks = 0;

  logic [7:0]  msg [0:15];
  logic [31:0] gotCrc;
  logic        gotDone, gotOk;

  always #2 clk = ~clk;

  crc32_engine dut (
    .clk(clk), .rst_n(rst_n), .validIn(validIn), .sopIn(sopIn), .eopIn(eopIn),
    .dataIn(dataIn), .cfgInvert(cfgInvert), .cfgCheck(cfgCheck),
    .crcOut(crcOut), .doneOut(doneOut), .crcOkOut(crcOkOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Register value after len bytes of msg, computed from the R2 rule
  function automatic logic [31:0] modelReg(input int len);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      r ^= {24'h0, msg[i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  // Send msg[0..len-1]; optional idle cycles carrying junk between bytes
  task automatic sendMsg(input int len, input logic inv, input logic chkm, input logic gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0) begin
        @(negedge clk);
        validIn = 1'b0; sopIn = 1'b1; eopIn = 1'b1; dataIn = 8'hA5 ^ 8'(i);
      end
      @(negedge clk);
      validIn = 1'b1; sopIn = (i == 0); eopIn = (i == len - 1); dataIn = msg[i];
      cfgInvert = inv; cfgCheck = chkm;
    end
    @(negedge clk);
    validIn = 1'b0; sopIn = 1'b0; eopIn = 1'b0; dataIn = 8'h00;
    cfgInvert = ~inv; cfgCheck = 1'b0;
    gotCrc = crcOut; gotDone = doneOut; gotOk = crcOkOut;
    @(negedge clk);
    chk("R7 done drops after one cycle", {31'h0, doneOut}, 32'h0);
    chk("R7 result holds", crcOut, gotCrc);
  endtask

  task automatic loadAscii();
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 crcOut in reset", crcOut, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 crcOut after reset", crcOut, 32'h0);
    chk("R1 doneOut after reset", {31'h0, doneOut}, 32'h0);
    chk("R1 crcOkOut after reset", {31'h0, crcOkOut}, 32'h0);
  endtask

  task automatic testKnown();
    msg[0] = 8'h00; sendMsg(1, 1'b1, 1'b0, 1'b0);
    chk("R5 byte 00", gotCrc, 32'hD202EF8D);
    chk("R7 done pulse", {31'h0, gotDone}, 32'h1);
    msg[0] = 8'h01; sendMsg(1, 1'b1, 1'b0, 1'b0);
    chk("R5 byte 01", gotCrc, 32'hA505DF1B);
    loadAscii(); sendMsg(9, 1'b1, 1'b0, 1'b0);
    chk("R5 check string", gotCrc, 32'hCBF43926);
    sendMsg(9, 1'b0, 1'b0, 1'b0);
    chk("R6 check string raw", gotCrc, 32'h340BC6D9);
    chk("R2 raw matches model", gotCrc, modelReg(9));
  endtask

  task automatic testGaps();
    loadAscii(); sendMsg(9, 1'b1, 1'b0, 1'b1);
    chk("R4 idle cycles ignored", gotCrc, 32'hCBF43926);
    chk("R9 no ok without check", {31'h0, gotOk}, 32'h0);
  endtask

  task automatic testRestart();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      validIn = 1'b1; sopIn = (i == 0); eopIn = 1'b0; dataIn = 8'h5A + 8'(i);
    end
    loadAscii(); sendMsg(9, 1'b1, 1'b0, 1'b0);
    chk("R3 restart discards partial", gotCrc, 32'hCBF43926);
  endtask

  task automatic testCheck();
    logic [31:0] c;
    loadAscii();
    c = modelReg(9);
    for (int k = 0; k < 4; k++) msg[9+k] = c[8*k +: 8];
    sendMsg(13, 1'b0, 1'b1, 1'b0);
    chk("R8 raw residue ok", {31'h0, gotOk}, 32'h1);
    chk("R8 raw residue value", gotCrc, 32'h0);
    c = ~c;
    for (int k = 0; k < 4; k++) msg[9+k] = c[8*k +: 8];
    sendMsg(13, 1'b1, 1'b1, 1'b0);
    chk("R8 standard residue ok", {31'h0, gotOk}, 32'h1);
    chk("R8 standard residue value", gotCrc, 32'h2144DF1C);
    sendMsg(13, 1'b1, 1'b0, 1'b0);
    chk("R9 check off gives no ok", {31'h0, gotOk}, 32'h0);
    msg[3] = msg[3] ^ 8'h10;
    sendMsg(13, 1'b1, 1'b1, 1'b0);
    chk("R9 corrupted message no ok", {31'h0, gotOk}, 32'h0);
  endtask

  task automatic testParticipation();
    logic [31:0] a, b;
    for (int i = 0; i < 8; i++) msg[i] = 8'h11 * 8'(i + 1);
    sendMsg(8, 1'b1, 1'b0, 1'b0); a = gotCrc;
    chk("R10 base message", a, ~modelReg(8));
    msg[0] = msg[0] ^ 8'h01;
    sendMsg(8, 1'b1, 1'b0, 1'b0); b = gotCrc;
    chk("R10 first byte changed", b, ~modelReg(8));
    msg[0] = msg[0] ^ 8'h01;
    msg[7] = msg[7] ^ 8'h01;
    sendMsg(8, 1'b1, 1'b0, 1'b0); b = gotCrc;
    chk("R10 last byte changed", b, ~modelReg(8));
    chk("R10 not a plain xor", {31'h0, (a ^ b) == 32'h01000000}, 32'h0);
  endtask

  initial begin
    testReset();
    testKnown();
    testGaps();
    testRestart();
    testCheck();
    testParticipation();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule